// File: doc/BRIEF.md
# Two-Level Interrupt Enable Controller

This block collects interrupt events for a small 8-bit processor core and decides when the core should branch to its interrupt handler. It serves three core sources (a rising edge on an external pin, a port-change pulse and a timer-overflow pulse) and up to sixteen peripheral sources. Every source has a sticky flag and its own enable bit. The peripheral sources must also pass a shared group enable. Every source then passes one global enable.

Software reaches the flags and enables through a small register port with an 8-bit data bus and a 3-bit select. The block raises a request line and presents a fixed vector address. It takes two strobes from the core: one when the core accepts the interrupt, and one when the handler returns. The accept strobe clears the global enable and the return strobe sets it again. Flags are never cleared by hardware. Software must write them to zero.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every flag, every enable, the group enable and the global enable read as 0, and `irq_req` is 0.
- R2: A source event sets its flag whether its own enable, the group enable or the global enable is set or not.
- R3: `irq_req` rises on the clock edge after the global enable is set and a core source has both its flag and its enable set.
- R4: A peripheral source raises `irq_req` only while the group enable is also set. The request appears one edge after the group enable is written to 1.
- R5: `irq_ack` clears the global enable and drops `irq_req` at the next edge. `irq_vector` always reads 0x0004.
- R6: `irq_ret` sets the global enable. If `irq_ack` arrives in the same cycle, `irq_ack` wins.
- R7: Neither the hardware nor the acknowledge ever clears a flag. A flag that is still set is taken again after `irq_ret`, and a software write of 0 stops the request.
- R8: If a source event and a register write of 0 reach the same flag in the same cycle, the flag ends up set.
- R9: Suppose `ext_pin` is first sampled high at clock edge k. Its flag reads 1 after edge k+2, and `irq_req` rises at edge k+3 when enabled. While the pin stays high, the flag is not set again.
- R10: A write that clears the global enable in the same cycle as `irq_ack` leaves the global enable at 0. A later `irq_ret` sets it back to 1.
- R11: Register map. Select 0 is the control register, with bit 7 global enable, bit 6 group enable, bit 5 timer enable, bit 4 pin enable, bit 3 port-change enable, bit 2 timer flag, bit 1 pin flag and bit 0 port-change flag. Select 1 and 2 hold the peripheral flags 7..0 and 15..8. Select 3 and 4 hold the matching enables. Selects 5 to 7 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_chg | input | 1 | Port-change event pulse |
| tmr_ovf | input | 1 | Timer overflow event pulse |
| periph_evt | input | 16 | Peripheral event pulses |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 13 | Handler entry address |
| irq_ack | input | 1 | Core accepts the interrupt |
| irq_ret | input | 1 | Return-from-interrupt strobe |

## Verification
The hardest situation to reach is the lost disable. Here a software write that clears the global enable meets the acknowledge in the same cycle, and the return from the handler later turns interrupts back on. The stimulus first raises a pending timer request. It then drives the acknowledge strobe and a control-register write in the same cycle, clears the flag, and issues the return strobe. At that point the control register shows the global enable set again. The event-versus-write collision on a flag is reached the same way, by driving the event and the write of 0 in the same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int DATA_W  = 8;
    localparam int SEL_W   = 3;
    localparam int PC_W    = 13;
    localparam int MAX_PER = 16;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL    = 3'd0,
        SEL_PFLG_LO = 3'd1,
        SEL_PFLG_HI = 3'd2,
        SEL_PEN_LO  = 3'd3,
        SEL_PEN_HI  = 3'd4
    } reg_sel_e;

    // control register, MSB first
    typedef struct packed {
        logic gie;
        logic pge;
        logic tmr_en;
        logic ext_en;
        logic chg_en;
        logic tmr_f;
        logic ext_f;
        logic chg_f;
    } ctrl_t;

    // sticky flag: write may clear, event always sets
    function automatic logic sticky_next(logic cur, logic wr, logic wbit, logic evt);
        return (wr ? wbit : cur) | evt;
    endfunction

    // global enable priority: acknowledge, then return, then software
    function automatic logic gie_next(logic cur, logic ack, logic ret, logic wr, logic wbit);
        if (ack)      return 1'b0;
        else if (ret) return 1'b1;
        else if (wr)  return wbit;
        else          return cur;
    endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_periph_bank.sv
module irq_periph_bank
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [MAX_PER-1:0] evt,
    input  logic [1:0]         flag_wr,
    input  logic [1:0]         en_wr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [MAX_PER-1:0] flags_o,
    output logic [MAX_PER-1:0] ens_o,
    output logic               pend_o
);
    for (genvar b = 0; b < MAX_PER; b++) begin : g_bit
        if (b < NUM_SRC) begin : g_live
            logic flag_q, en_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    flag_q <= 1'b0;
                    en_q   <= 1'b0;
                end else begin
                    flag_q <= sticky_next(flag_q, flag_wr[b/DATA_W], wdata[b%DATA_W], evt[b]);
                    if (en_wr[b/DATA_W]) en_q <= wdata[b%DATA_W];
                end
            end
            assign flags_o[b] = flag_q;
            assign ens_o[b]   = en_q;
        end else begin : g_tie
            assign flags_o[b] = 1'b0;
            assign ens_o[b]   = 1'b0;
        end
    end

    assign pend_o = |(flags_o & ens_o);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int              NUM_PERIPH  = 16,
    parameter int              SYNC_STAGES = 2,
    parameter logic [PC_W-1:0] VECTOR_ADDR = 13'h0004
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_pin,
    input  logic               port_chg,
    input  logic               tmr_ovf,
    input  logic [MAX_PER-1:0] periph_evt,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_req,
    output logic [PC_W-1:0]    irq_vector,
    input  logic               irq_ack,
    input  logic               irq_ret
);
    ctrl_t              ctrl_q, ctrl_d, wctrl;
    logic               ext_rise;
    logic               wr_ctrl;
    logic [1:0]         pflag_wr, pen_wr;
    logic [MAX_PER-1:0] pflag, pen;
    logic               per_pend, core_pend;
    logic               irq_req_q;
    logic               gie_w;
    logic [2:0]         core_flags_w;

    irq_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_in (ext_pin),
        .rise_o (ext_rise)
    );

    always_comb begin
        wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
        pflag_wr = {reg_wr && (reg_sel == SEL_PFLG_HI), reg_wr && (reg_sel == SEL_PFLG_LO)};
        pen_wr   = {reg_wr && (reg_sel == SEL_PEN_HI),  reg_wr && (reg_sel == SEL_PEN_LO)};
    end

    irq_periph_bank #(.NUM_SRC(NUM_PERIPH)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .evt     (periph_evt),
        .flag_wr (pflag_wr),
        .en_wr   (pen_wr),
        .wdata   (reg_wdata),
        .flags_o (pflag),
        .ens_o   (pen),
        .pend_o  (per_pend)
    );

    assign wctrl = ctrl_t'(reg_wdata);

    always_comb begin
        ctrl_d        = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.pge    = wctrl.pge;
            ctrl_d.tmr_en = wctrl.tmr_en;
            ctrl_d.ext_en = wctrl.ext_en;
            ctrl_d.chg_en = wctrl.chg_en;
        end
        ctrl_d.tmr_f = sticky_next(ctrl_q.tmr_f, wr_ctrl, wctrl.tmr_f, tmr_ovf);
        ctrl_d.ext_f = sticky_next(ctrl_q.ext_f, wr_ctrl, wctrl.ext_f, ext_rise);
        ctrl_d.chg_f = sticky_next(ctrl_q.chg_f, wr_ctrl, wctrl.chg_f, port_chg);
        ctrl_d.gie   = gie_next(ctrl_q.gie, irq_ack, irq_ret, wr_ctrl, wctrl.gie);
    end

    assign core_pend = (ctrl_q.tmr_f & ctrl_q.tmr_en)
                     | (ctrl_q.ext_f & ctrl_q.ext_en)
                     | (ctrl_q.chg_f & ctrl_q.chg_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            irq_req_q <= 1'b0;
        end else begin
            ctrl_q    <= ctrl_d;
            irq_req_q <= !irq_ack && ctrl_q.gie && (core_pend || (ctrl_q.pge && per_pend));
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_CTRL:    reg_rdata = ctrl_q;
            SEL_PFLG_LO: reg_rdata = pflag[7:0];
            SEL_PFLG_HI: reg_rdata = pflag[15:8];
            SEL_PEN_LO:  reg_rdata = pen[7:0];
            SEL_PEN_HI:  reg_rdata = pen[15:8];
            default:     reg_rdata = '0;
        endcase
    end

    assign irq_req      = irq_req_q;
    assign irq_vector   = VECTOR_ADDR;
    assign gie_w        = ctrl_q.gie;
    assign core_flags_w = {ctrl_q.tmr_f, ctrl_q.ext_f, ctrl_q.chg_f};
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               irq_ack,
    input logic               irq_ret,
    input logic               irq_req,
    input logic               reg_wr,
    input logic               tmr_ovf,
    input logic               gie,
    input logic [2:0]         core_flags,
    input logic [MAX_PER-1:0] pflags
);
    p_ack_clears_gie_r5: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !gie);

    p_ack_drops_req_r5: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_req);

    p_ret_sets_gie_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_ret && !irq_ack) |=> gie);

    p_req_needs_gie_r3: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> $past(gie));

    p_core_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> ((core_flags & $past(core_flags)) == $past(core_flags)));

    p_per_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> ((pflags & $past(pflags)) == $past(pflags)));

    p_event_wins_r8: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf |=> core_flags[2]);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_ack    (irq_ack),
    .irq_ret    (irq_ret),
    .irq_req    (irq_req),
    .reg_wr     (reg_wr),
    .tmr_ovf    (tmr_ovf),
    .gie        (gie_w),
    .core_flags (core_flags_w),
    .pflags     (pflag)
);

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_pin = 1'b0, port_chg = 1'b0, tmr_ovf = 1'b0;
    logic [15:0] periph_evt = '0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_req;
    logic [12:0] irq_vector;
    logic        irq_ack = 1'b0, irq_ret = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_ctrl u0 (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .port_chg(port_chg), .tmr_ovf(tmr_ovf),
        .periph_evt(periph_evt), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vector(irq_vector),
        .irq_ack(irq_ack), .irq_ret(irq_ret)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] sel, logic [7:0] data);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] sel, output logic [7:0] val);
        reg_sel = sel;
        #1 val = reg_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        for (int s = 0; s < 5; s++) begin
            rd(3'(s), v);
            check("R1", 16'(v), 16'h0, $sformatf("reg %0d after reset", s));
        end
        check("R1", 16'(irq_req), 16'h0, "irq_req after reset");
        check("R5", 16'(irq_vector), 16'h0004, "vector");
    endtask

    task automatic t_masked();
        logic [7:0] v;
        do_reset();
        tmr_ovf = 1'b1; port_chg = 1'b1; periph_evt = 16'h0201;
        tick(1);
        tmr_ovf = 1'b0; port_chg = 1'b0; periph_evt = '0;
        rd(0, v); check("R2", 16'(v), 16'h05, "core flags with masks off");
        rd(1, v); check("R2", 16'(v), 16'h01, "periph flags lo");
        rd(2, v); check("R2", 16'(v), 16'h02, "periph flags hi");
        tick(1);
        check("R2", 16'(irq_req), 16'h0, "no request while masked");
    endtask

    task automatic t_core();
        do_reset();
        wr(0, 8'hA0);
        tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
        check("R3", 16'(irq_req), 16'h0, "req one edge after event");
        tick(1);
        check("R3", 16'(irq_req), 16'h1, "req after flag and enable");
    endtask

    task automatic t_periph();
        do_reset();
        wr(3, 8'h08);
        wr(0, 8'h80);
        periph_evt[3] = 1'b1; tick(1); periph_evt[3] = 1'b0;
        tick(2);
        check("R4", 16'(irq_req), 16'h0, "no req without group enable");
        wr(0, 8'hC0);
        check("R4", 16'(irq_req), 16'h0, "req not yet at group write edge");
        tick(1);
        check("R4", 16'(irq_req), 16'h1, "req with group enable");
    endtask

    task automatic t_ack_ret();
        logic [7:0] v;
        do_reset();
        wr(0, 8'hA0);
        tmr_ovf = 1'b1; tick(2); tmr_ovf = 1'b0;
        check("R3", 16'(irq_req), 16'h1, "req before ack");
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
        check("R5", 16'(irq_req), 16'h0, "req dropped by ack");
        rd(0, v); check("R7", 16'(v), 16'h24, "ack clears gie, keeps flag");
        tick(2);
        check("R5", 16'(irq_req), 16'h0, "req stays low after ack");
        irq_ret = 1'b1; tick(1); irq_ret = 1'b0;
        rd(0, v); check("R6", 16'(v), 16'hA4, "ret sets gie");
        tick(1);
        check("R7", 16'(irq_req), 16'h1, "uncleared flag retaken");
        irq_ack = 1'b1; irq_ret = 1'b1; tick(1); irq_ack = 1'b0; irq_ret = 1'b0;
        rd(0, v); check("R6", 16'(v), 16'h24, "ack beats ret");
        wr(0, 8'h20);
        irq_ret = 1'b1; tick(1); irq_ret = 1'b0;
        tick(2);
        check("R7", 16'(irq_req), 16'h0, "software clear stops req");
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        do_reset();
        port_chg = 1'b1;
        wr(0, 8'h00);
        port_chg = 1'b0;
        rd(0, v); check("R8", 16'(v), 16'h01, "core event beats write 0");
        periph_evt[5] = 1'b1; tick(1); periph_evt[5] = 1'b0;
        periph_evt[6] = 1'b1;
        wr(1, 8'h00);
        periph_evt[6] = 1'b0;
        rd(1, v); check("R8", 16'(v), 16'h40, "periph event beats write 0");
    endtask

    task automatic t_ext();
        logic [7:0] v;
        do_reset();
        wr(0, 8'h90);
        ext_pin = 1'b1;
        tick(2);
        rd(0, v); check("R9", 16'(v), 16'h90, "flag not yet at k+1");
        tick(1);
        rd(0, v); check("R9", 16'(v), 16'h92, "flag at k+2");
        check("R9", 16'(irq_req), 16'h0, "req not yet at k+2");
        tick(1);
        check("R9", 16'(irq_req), 16'h1, "req at k+3");
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
        wr(0, 8'h90);
        tick(4);
        rd(0, v); check("R9", 16'(v), 16'h90, "steady level sets no flag");
        check("R9", 16'(irq_req), 16'h0, "no req on steady level");
        ext_pin = 1'b0;
    endtask

    task automatic t_race();
        logic [7:0] v;
        do_reset();
        wr(0, 8'hA0);
        tmr_ovf = 1'b1; tick(2); tmr_ovf = 1'b0;
        irq_ack = 1'b1;
        wr(0, 8'h24);
        irq_ack = 1'b0;
        check("R10", 16'(irq_req), 16'h0, "req dropped in race");
        rd(0, v); check("R10", 16'(v), 16'h24, "gie clear in race");
        wr(0, 8'h20);
        irq_ret = 1'b1; tick(1); irq_ret = 1'b0;
        rd(0, v); check("R10", 16'(v), 16'hA0, "ret undoes software clear");
    endtask

    task automatic t_map();
        logic [7:0] v;
        do_reset();
        wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
        for (int s = 0; s < 8; s++) begin
            rd(3'(s), v);
            check("R11", 16'(v), 16'h0, $sformatf("reg %0d after unused writes", s));
        end
        wr(4, 8'hA5); wr(3, 8'h3C);
        rd(4, v); check("R11", 16'(v), 16'hA5, "enable hi readback");
        rd(3, v); check("R11", 16'(v), 16'h3C, "enable lo readback");
        wr(0, 8'h78);
        rd(0, v); check("R11", 16'(v), 16'h78, "ctrl enables readback");
    endtask

    initial begin
        t_reset();
        t_masked();
        t_core();
        t_periph();
        t_ack_ret();
        t_set_wins();
        t_ext();
        t_race();
        t_map();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule